// File: doc/BRIEF.md
# Exception Control and Status Registers

This block is the software-visible register face of a small interrupt controller. It keeps pending flags for a system timer exception and for a deferred service call exception. It also keeps pending and enable bits for a vector of peripheral interrupt lines. From these it reports two things: the number of the highest-priority pending enabled exception, and a summary flag that shows whether anything is pending at all. It also records the number of the exception currently being handled, which it learns from an enter/exit handshake with the core.

Software reaches the block through a plain 32-bit register bus. Reads are combinational. Writes are taken on the rising clock edge when the write enable is high. Pending flags are set and cleared through separate write-one strobe bits, and the hardware sources can also set them. A control register is protected by a 16-bit key: only writes carrying the key change it. Exception numbers are fixed. The service call is 14, the timer is 15, and peripheral line i is 16+i. A lower number means a higher priority.

Top module: `exc_ctrl_regs`

## Requirements
- R1: After reset, all four registers read 0: status at byte address 0x0, enable at 0x4, peripheral pending at 0x8 and control at 0xC. ctrl_o is also 0.
- R2: In the status word, writing 1 to bit 25 clears the timer pending flag. Writing 0 to bit 25 leaves the flag unchanged.
- R3: The timer pending flag is set by writing 1 to status bit 26 or by a tick_i pulse. If bits 26 and 25 are written as 1 together, the flag ends up clear. If tick_i is high in the same cycle as a bit-25 clear, the flag stays set.
- R4: The service call pending flag is set by writing 1 to status bit 28 and cleared by writing 1 to bit 27. If both bits are written as 1 together, the flag ends up clear.
- R5: Status bits 25 to 28 always read as 0. Every status bit outside 22, 17:12 and 5:0 reads as 0.
- R6: Status bit 22 is 1 whenever any flag is pending: the timer flag, the service call flag, or any peripheral pending bit, whether that line is enabled or not.
- R7: Status bits [17:12] give the lowest exception number among the pending enabled exceptions, or 0 when there is none. The service call (14) and the timer (15) are always enabled. Peripheral line i (number 16+i) counts only when bit i of the enable register is set.
- R8: Status bits [5:0] hold the active exception number. An enter_i pulse loads enter_num_i. An exit_i pulse loads 0. If enter_i and exit_i arrive in the same cycle, enter_i wins.
- R9: A write to the enable register (0x4) sets the enable bits. A pulse on irq_i[i] sets peripheral pending bit i. Writing 1 to bit i at 0x8 clears that bit, unless irq_i[i] is high in the same cycle, in which case the bit stays set.
- R10: A write to the control register (0xC) loads wdata[CTRL_W-1:0] into the register and into ctrl_o only when wdata[31:16] equals KEY (0x05FA by default). Any other key leaves the register unchanged. Reads of 0xC return the stored value in the low bits and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 4 | Byte address; bits [3:2] select the register |
| we | input | 1 | Write enable |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational) |
| tick_i | input | 1 | Timer request pulse |
| irq_i | input | NUM_IRQ | Peripheral request pulses |
| enter_i | input | 1 | Exception entry strobe |
| enter_num_i | input | 6 | Number of the exception being entered |
| exit_i | input | 1 | Exception return strobe |
| ctrl_o | output | CTRL_W | Stored control value |

## Verification
The bench uses the default parameters: eight peripheral lines, a four-bit control field and key 0x05FA. With eight lines, enabled and disabled peripherals can be mixed in a few writes. This makes it possible to check every ordering in the priority encoder: service call over timer, timer over the peripherals, and a lower line over a higher one. With the four-bit control field, a single write fills the whole register, so the accepted-key and rejected-key cases can be observed completely at both rdata and ctrl_o.

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs #(
  parameter int NUM_IRQ = 8,
  parameter int CTRL_W = 4,
  parameter logic [15:0] KEY = 16'h05FA
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         addr,
  input  logic               we,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic               tick_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               enter_i,
  input  logic [5:0]         enter_num_i,
  input  logic               exit_i,
  output logic [CTRL_W-1:0]  ctrl_o
);
  localparam int SVC_NUM = 14;
  localparam int TMR_NUM = 15;
  localparam int IRQ_BASE = 16;
  localparam int B_TCLR = 25;
  localparam int B_TSET = 26;
  localparam int B_SCLR = 27;
  localparam int B_SSET = 28;

  logic               pend_tmr, pend_svc;
  logic [NUM_IRQ-1:0] irq_pend, irq_en;
  logic [5:0]         active, pnum;
  logic [CTRL_W-1:0]  ctrl_q;
  logic               summary;

  wire wr_st   = we && addr[3:2] == 2'd0;
  wire wr_en   = we && addr[3:2] == 2'd1;
  wire wr_pend = we && addr[3:2] == 2'd2;
  wire wr_ctl  = we && addr[3:2] == 2'd3 && wdata[31:16] == KEY;

  wire tclr = wr_st && wdata[B_TCLR];
  wire tset = wr_st && wdata[B_TSET];
  wire sclr = wr_st && wdata[B_SCLR];
  wire sset = wr_st && wdata[B_SSET];
  wire [NUM_IRQ-1:0] iclr = wr_pend ? wdata[NUM_IRQ-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_tmr <= 1'b0;
      pend_svc <= 1'b0;
      irq_pend <= '0;
      irq_en   <= '0;
      active   <= '0;
      ctrl_q   <= '0;
    end else begin
      pend_tmr <= tick_i | ((pend_tmr | tset) & ~tclr);
      pend_svc <= (pend_svc | sset) & ~sclr;
      irq_pend <= irq_i | (irq_pend & ~iclr);
      if (wr_en) irq_en <= wdata[NUM_IRQ-1:0];
      if (enter_i) active <= enter_num_i;
      else if (exit_i) active <= '0;
      if (wr_ctl) ctrl_q <= wdata[CTRL_W-1:0];
    end
  end

  always_comb begin
    pnum = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--)
      if (irq_pend[i] && irq_en[i]) pnum = 6'(IRQ_BASE + i);
    if (pend_tmr) pnum = 6'(TMR_NUM);
    if (pend_svc) pnum = 6'(SVC_NUM);
  end

  assign summary = pend_tmr | pend_svc | (|irq_pend);

  always_comb begin
    rdata = '0;
    case (addr[3:2])
      2'd0: begin
        rdata[22]    = summary;
        rdata[17:12] = pnum;
        rdata[5:0]   = active;
      end
      2'd1: rdata[NUM_IRQ-1:0] = irq_en;
      2'd2: rdata[NUM_IRQ-1:0] = irq_pend;
      default: rdata[CTRL_W-1:0] = ctrl_q;
    endcase
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/exc_ctrl_regs_chk.sv
module exc_ctrl_regs_chk #(
  parameter int CTRL_W = 4,
  parameter logic [15:0] KEY = 16'h05FA
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        addr,
  input logic              we,
  input logic [31:0]       wdata,
  input logic              tick_i,
  input logic              enter_i,
  input logic [5:0]        enter_num_i,
  input logic              exit_i,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              pend_tmr,
  input logic [5:0]        active,
  input logic [5:0]        pnum,
  input logic              summary
);
  a_r2_timer_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr[3:2] == 2'd0 && wdata[25] && !tick_i) |=> !pend_tmr);
  a_r3_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> pend_tmr);
  a_r8_enter_loads: assert property (@(posedge clk) disable iff (!rst_n)
    enter_i |=> active == $past(enter_num_i));
  a_r8_exit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_i && !enter_i) |=> active == 6'd0);
  a_r10_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr[3:2] == 2'd3 && wdata[31:16] != KEY) |=> $stable(ctrl_o));
  a_r6_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (pnum != 6'd0) |-> summary);
endmodule

bind exc_ctrl_regs exc_ctrl_regs_chk #(.CTRL_W(CTRL_W), .KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
  .tick_i(tick_i), .enter_i(enter_i), .enter_num_i(enter_num_i),
  .exit_i(exit_i), .ctrl_o(ctrl_o), .pend_tmr(pend_tmr),
  .active(active), .pnum(pnum), .summary(summary)
);

// File: tb/exc_ctrl_regs_bench.sv
module exc_ctrl_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 8;

  logic            clk = 0, rst_n = 0;
  logic [3:0]      addr = 0;
  logic            we = 0;
  logic [31:0]     wdata = 0;
  logic [31:0]     rdata;
  logic            tick_i = 0;
  logic [NIRQ-1:0] irq_i = 0;
  logic            enter_i = 0, exit_i = 0;
  logic [5:0]      enter_num_i = 0;
  logic [3:0]      ctrl_o;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_ctrl_regs #(.NUM_IRQ(NIRQ), .CTRL_W(4)) u_exc_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
    .rdata(rdata), .tick_i(tick_i), .irq_i(irq_i), .enter_i(enter_i),
    .enter_num_i(enter_num_i), .exit_i(exit_i), .ctrl_o(ctrl_o)
  );

  function automatic logic [31:0] st(bit s, int pn, int act);
    return (32'(s) << 22) | (32'(pn) << 12) | 32'(act);
  endfunction

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    addr = a; we = 0;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d,
                    input bit t = 0, input logic [NIRQ-1:0] q = '0);
    @(negedge clk);
    addr = a; we = 1; wdata = d; tick_i = t; irq_i = q;
    @(negedge clk);
    we = 0; wdata = 0; tick_i = 0; irq_i = 0;
  endtask

  task automatic hs(input bit en, input bit ex, input logic [5:0] n);
    @(negedge clk);
    enter_i = en; exit_i = ex; enter_num_i = n;
    @(negedge clk);
    enter_i = 0; exit_i = 0;
  endtask

  task automatic chk_ctrl(input logic [3:0] e, input string t);
    total++;
    if (ctrl_o !== e) begin
      bad++;
      $display("FAIL %s ctrl_o actual=%h expected=%h", t, ctrl_o, e);
    end
  endtask

  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rdata !== e) begin
        bad++;
        $display("FAIL %s addr=%h actual=%h expected=%h", t, addr, rdata, e);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(4'h0, 0, "R1 status"); rd(4'h4, 0, "R1 enable");
    rd(4'h8, 0, "R1 pending"); rd(4'hC, 0, "R1 control");
    chk_ctrl(0, "R1");

    wr(4'h0, 32'h1 << 26);
    rd(4'h0, st(1, 15, 0), "R3 sw set timer");
    wr(4'h0, 32'h0);
    rd(4'h0, st(1, 15, 0), "R2 zero write no effect");
    wr(4'h0, 32'h1 << 25);
    rd(4'h0, 0, "R2 clear timer");
    wr(4'h0, (32'h1 << 26) | (32'h1 << 25));
    rd(4'h0, 0, "R3 set+clear resolves clear");
    wr(4'h0, 0, 1);
    rd(4'h0, st(1, 15, 0), "R3 tick sets");
    wr(4'h0, 32'h1 << 25, 1);
    rd(4'h0, st(1, 15, 0), "R3 tick beats clear");
    wr(4'h0, 32'h1 << 25);

    wr(4'h0, 32'h1 << 28);
    rd(4'h0, st(1, 14, 0), "R4 set service call");
    wr(4'h0, 0, 1);
    rd(4'h0, st(1, 14, 0), "R7 service call over timer");
    wr(4'h0, 32'h1 << 27);
    rd(4'h0, st(1, 15, 0), "R4 clear service call");
    wr(4'h0, (32'h1 << 28) | (32'h1 << 27));
    rd(4'h0, st(1, 15, 0), "R4 set+clear resolves clear");
    wr(4'h0, 32'h1 << 25);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, 0, "R5 strobes and reserved read zero");

    wr(4'h0, 0, 0, 8'h08);
    rd(4'h8, 32'h08, "R9 irq pulse sets pending");
    rd(4'h0, st(1, 0, 0), "R6 summary with disabled line");
    wr(4'h4, 32'h08);
    rd(4'h4, 32'h08, "R9 enable readback");
    rd(4'h0, st(1, 19, 0), "R7 enabled line 3");
    wr(4'h0, 0, 0, 8'h02);
    wr(4'h4, 32'h0A);
    rd(4'h0, st(1, 17, 0), "R7 lower line wins");
    wr(4'h0, 0, 1);
    rd(4'h0, st(1, 15, 0), "R7 timer over peripherals");
    wr(4'h0, 32'h1 << 25);
    wr(4'h8, 32'h02, 0, 8'h02);
    rd(4'h8, 32'h0A, "R9 irq beats clear");
    wr(4'h8, 32'h0A);
    rd(4'h8, 0, "R9 clear pending");
    rd(4'h0, 0, "R6 summary drops");

    hs(1, 0, 6'd21);
    rd(4'h0, st(0, 0, 21), "R8 enter");
    hs(0, 1, 0);
    rd(4'h0, 0, "R8 exit");
    hs(1, 1, 6'd9);
    rd(4'h0, st(0, 0, 9), "R8 enter wins over exit");
    hs(0, 1, 0);

    wr(4'hC, 32'h1234_000F);
    rd(4'hC, 0, "R10 wrong key ignored");
    chk_ctrl(0, "R10 wrong key");
    wr(4'hC, 32'h05FA_0005);
    rd(4'hC, 32'h5, "R10 key accepted");
    chk_ctrl(4'h5, "R10 key accepted");
    wr(4'hC, 32'h05FB_000A);
    rd(4'hC, 32'h5, "R10 near key ignored");
    chk_ctrl(4'h5, "R10 near key");

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule